// File: doc/BRIEF.md
# Sleep Mode and Clock Gating Controller

This controller sits next to a small processor core and decides which clock domains run. Software sets a sleep-enable bit and a two-bit mode field, then executes the sleep instruction. The core turns that instruction into a one-cycle pulse on `slp_pulse_i`. When the pulse arrives with the enable bit set, the controller latches the mode and gates the clock domains that the mode stops.

While the core sleeps, the controller watches the enabled interrupt requests and filters them by the latched mode. A request that the mode allows starts the wake sequence. In Power-down the oscillator must restart first, so the sequence waits a start-up time. Every mode then holds the CPU stalled for four more cycles with its clocks running, after which the controller returns to normal operation and issues a one-cycle completion strobe. The interrupt controller then services the request.

The controller never asserts a reset, so register and memory contents survive sleep. An asynchronous reset cancels any sleep or wake sequence at once and leaves the core on its reset path, with no completion strobe. No data flows through this block, so every pin is a plain level or pulse and there is no valid/ready handshake or back-pressure.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: A sleep pulse enters sleep only if `slp_en_i` is 1 in the same cycle. A pulse with `slp_en_i` at 0 leaves all clock enables high and `cpu_stall_o` low.
- R2: Mode code 00 is Idle. In Idle, `cpu_clk_en_o` and `flash_clk_en_o` are low, and the I/O clock, the ADC/asynchronous clock and the oscillator stay enabled. All enables take their sleep values in the cycle after the accepted pulse.
- R3: Mode code 01 is ADC Noise Reduction. Only `adc_clk_en_o` and `osc_run_o` stay high.
- R4: Mode code 11 is Standby. All four clock enables are low and `osc_run_o` stays high.
- R5: Mode code 10 is Power-down. All four clock enables and `osc_run_o` are low.
- R6: Request bit i of `irq_req_i` wakes the core as follows:
  - In Idle, any bit wakes it.
  - In ADC Noise Reduction, a bit wakes it only if it is set in `ADC_WAKE_MASK` (default 4'b0111).
  - In Standby and Power-down, a bit wakes it only if it is set in `DEEP_WAKE_MASK` (default 4'b0011).
  - A request that the mode does not allow leaves the core asleep with its enables unchanged.
- R7: Bit 0 is external interrupt 0. Outside Idle it wakes the core only while `int0_level_i` is 1, meaning that interrupt is set up as level-triggered.
- R8: Let edge m be the clock edge at which an allowed request is sampled during sleep. `wake_done_o` is high after edge m+S+4 and `cpu_stall_o` stays high until then. S is `PD_STARTUP` in Power-down and 0 in every other mode.
- R9: `wake_done_o` is high for exactly one cycle. In that cycle every clock enable and `osc_run_o` is high and `cpu_stall_o` is low.
- R10: Reset low makes every enable high and `cpu_stall_o` low at once. After release, `wake_done_o` stays low until a later wake.
- R11: During the Power-down start-up wait, only `osc_run_o` is high. During the four halt cycles, all enables are high and `cpu_stall_o` is high.
- R12: Sleep pulses that arrive while the core is asleep or waking are ignored. Requests held during the wake sequence do not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_en_i | input | 1 | Sleep-enable control bit |
| mode_i | input | 2 | Sleep mode select (00 Idle, 01 ADC NR, 10 Power-down, 11 Standby) |
| slp_pulse_i | input | 1 | One-cycle pulse from the sleep instruction |
| irq_req_i | input | NIRQ | Enabled interrupt requests, bit 0 is external interrupt 0 |
| int0_level_i | input | 1 | External interrupt 0 is set up as level-triggered |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| flash_clk_en_o | output | 1 | Program memory clock enable |
| io_clk_en_o | output | 1 | I/O and peripheral clock enable |
| adc_clk_en_o | output | 1 | ADC and asynchronous clock enable |
| osc_run_o | output | 1 | Oscillator run enable |
| cpu_stall_o | output | 1 | CPU held from fetching |
| wake_done_o | output | 1 | One-cycle strobe when the wake sequence ends |

## Verification
The bench sweeps every mode against every request bit and both settings of the external interrupt trigger. It predicts from the masks whether each request should wake the core. A controller with a wrong filter would either wake on a request the mode forbids or sleep through an allowed one, and external interrupt 0 set up as edge-triggered is the case a naive filter gets wrong.

The bench counts the cycles from request to strobe in each mode and compares the count with start-up plus four. An off-by-one counter, or a start-up wait applied outside Power-down, shows up as a wrong count. It also checks the enables inside the start-up window, so a design that ungates clocks before the oscillator is stable is caught.

Stray sleep pulses during sleep must not re-latch the mode. A reset in mid-sleep must restore the clocks without a false completion strobe.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'b00,
    MD_ADCNR = 2'b01,
    MD_PDOWN = 2'b10,
    MD_STBY  = 2'b11
  } slp_mode_e;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_SLEEP   = 2'b01,
    ST_STARTUP = 2'b10,
    ST_HALT4   = 2'b11
  } slp_state_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic osc;
  } clk_en_t;

  localparam int unsigned HALT_CYC = 4;

endpackage

// File: rtl/slp_wake_filter.sv
module slp_wake_filter
  import slp_pkg::*;
#(
  parameter int unsigned NIRQ = 4,
  parameter logic [NIRQ-1:0] ADC_WAKE_MASK = '1,
  parameter logic [NIRQ-1:0] DEEP_WAKE_MASK = '1
) (
  input  slp_mode_e        mode_i,
  input  logic [NIRQ-1:0]  irq_req_i,
  input  logic             int0_level_i,
  output logic             wake_o
);

  logic [NIRQ-1:0] allow;
  logic            is_idle;
  logic            is_adc;

  assign is_idle = (mode_i == MD_IDLE);
  assign is_adc  = (mode_i == MD_ADCNR);

  for (genvar i = 0; i < NIRQ; i++) begin : g_src
    if (i == 0) begin : g_int0
      // external interrupt 0: outside Idle only its level form counts
      assign allow[i] = is_idle ||
                        (int0_level_i && (is_adc ? ADC_WAKE_MASK[i] : DEEP_WAKE_MASK[i]));
    end else begin : g_other
      assign allow[i] = is_idle || (is_adc ? ADC_WAKE_MASK[i] : DEEP_WAKE_MASK[i]);
    end
  end

  assign wake_o = |(irq_req_i & allow);

endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int unsigned PD_STARTUP = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_i,
  input  slp_mode_e  mode_i,
  input  logic       wake_i,
  output slp_state_e state_o,
  output slp_mode_e  mode_q_o,
  output logic       done_o
);

  localparam int unsigned CNT_MAX = (PD_STARTUP > HALT_CYC) ? PD_STARTUP : HALT_CYC;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);
  localparam int unsigned SU_LAST = (PD_STARTUP > 0) ? PD_STARTUP - 1 : 0;
  localparam logic [CW-1:0] SU_END = CW'(SU_LAST);
  localparam logic [CW-1:0] HT_END = CW'(HALT_CYC - 1);

  slp_state_e    state_q;
  slp_mode_e     mode_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      mode_q  <= MD_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_ACTIVE: begin
          if (enter_i) begin
            state_q <= ST_SLEEP;
            mode_q  <= mode_i;
          end
        end
        ST_SLEEP: begin
          if (wake_i) begin
            cnt_q <= '0;
            if ((mode_q == MD_PDOWN) && (PD_STARTUP > 0)) state_q <= ST_STARTUP;
            else                                          state_q <= ST_HALT4;
          end
        end
        ST_STARTUP: begin
          if (cnt_q == SU_END) begin
            state_q <= ST_HALT4;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HALT4: begin
          if (cnt_q == HT_END) begin
            state_q <= ST_ACTIVE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_ACTIVE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign mode_q_o = mode_q;
  assign done_o   = done_q;

endmodule

// File: rtl/slp_clk_map.sv
module slp_clk_map
  import slp_pkg::*;
(
  input  slp_state_e state_i,
  input  slp_mode_e  mode_i,
  output clk_en_t    en_o,
  output logic       stall_o
);

  always_comb begin
    en_o    = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
    stall_o = 1'b1;
    unique case (state_i)
      ST_ACTIVE: stall_o = 1'b0;
      ST_SLEEP: begin
        unique case (mode_i)
          MD_IDLE:  en_o = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, adc: 1'b1, osc: 1'b1};
          MD_ADCNR: en_o = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b1, osc: 1'b1};
          MD_STBY:  en_o = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
          MD_PDOWN: en_o = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b0};
          default:  en_o = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b0};
        endcase
      end
      ST_STARTUP: en_o = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
      ST_HALT4:   en_o = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
      default:    stall_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
  import slp_pkg::*;
#(
  parameter int unsigned NIRQ = 4,
  parameter int unsigned PD_STARTUP = 16,
  parameter logic [NIRQ-1:0] ADC_WAKE_MASK = 4'b0111,
  parameter logic [NIRQ-1:0] DEEP_WAKE_MASK = 4'b0011
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slp_en_i,
  input  logic [1:0]      mode_i,
  input  logic            slp_pulse_i,
  input  logic [NIRQ-1:0] irq_req_i,
  input  logic            int0_level_i,
  output logic            cpu_clk_en_o,
  output logic            flash_clk_en_o,
  output logic            io_clk_en_o,
  output logic            adc_clk_en_o,
  output logic            osc_run_o,
  output logic            cpu_stall_o,
  output logic            wake_done_o
);

  slp_state_e state;
  slp_mode_e  mode_q;
  logic       wake;
  logic       enter;
  clk_en_t    en;

  assign enter = slp_pulse_i & slp_en_i;

  slp_wake_filter #(
    .NIRQ(NIRQ),
    .ADC_WAKE_MASK(ADC_WAKE_MASK),
    .DEEP_WAKE_MASK(DEEP_WAKE_MASK)
  ) u_filt (
    .mode_i(mode_q),
    .irq_req_i(irq_req_i),
    .int0_level_i(int0_level_i),
    .wake_o(wake)
  );

  slp_seq #(
    .PD_STARTUP(PD_STARTUP)
  ) u_seq (
    .clk(clk),
    .rst_n(rst_n),
    .enter_i(enter),
    .mode_i(slp_mode_e'(mode_i)),
    .wake_i(wake),
    .state_o(state),
    .mode_q_o(mode_q),
    .done_o(wake_done_o)
  );

  slp_clk_map u_map (
    .state_i(state),
    .mode_i(mode_q),
    .en_o(en),
    .stall_o(cpu_stall_o)
  );

  assign cpu_clk_en_o   = en.cpu;
  assign flash_clk_en_o = en.flash;
  assign io_clk_en_o    = en.io;
  assign adc_clk_en_o   = en.adc;
  assign osc_run_o      = en.osc;

endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk #(
  parameter int unsigned NIRQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            slp_en_i,
  input logic [1:0]      mode_i,
  input logic            slp_pulse_i,
  input logic [NIRQ-1:0] irq_req_i,
  input logic            int0_level_i,
  input logic            cpu_clk_en_o,
  input logic            flash_clk_en_o,
  input logic            io_clk_en_o,
  input logic            adc_clk_en_o,
  input logic            osc_run_o,
  input logic            cpu_stall_o,
  input logic            wake_done_o
);

  // R1
  en_low_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_pulse_i && !slp_en_i && !cpu_stall_o) |=> !cpu_stall_o);

  // R5
  osc_off_all_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run_o |-> !(cpu_clk_en_o || flash_clk_en_o || io_clk_en_o || adc_clk_en_o));

  // R8
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall_o) |-> wake_done_o);

  // R9
  done_clocks_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done_o |-> (cpu_clk_en_o && flash_clk_en_o && io_clk_en_o && adc_clk_en_o
                     && osc_run_o && !cpu_stall_o));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done_o |=> !wake_done_o);

  // R2
  cpu_gate_needs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en_o |-> cpu_stall_o);

endmodule

bind sleep_clk_ctrl slp_ctrl_chk #(.NIRQ(NIRQ)) u_chk (.*);

// File: tb/sim_sleep_clk_ctrl.sv
module sim_sleep_clk_ctrl;

  localparam int NIRQ = 4;
  localparam int SU   = 6;
  localparam logic [3:0] ADC_M  = 4'b0111;
  localparam logic [3:0] DEEP_M = 4'b0011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slp_en_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic slp_pulse_i = 1'b0;
  logic [NIRQ-1:0] irq_req_i = '0;
  logic int0_level_i = 1'b0;
  logic cpu_clk_en_o, flash_clk_en_o, io_clk_en_o, adc_clk_en_o, osc_run_o;
  logic cpu_stall_o, wake_done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  sleep_clk_ctrl #(
    .NIRQ(NIRQ), .PD_STARTUP(SU), .ADC_WAKE_MASK(ADC_M), .DEEP_WAKE_MASK(DEEP_M)
  ) u0 (.*);

  function automatic logic [4:0] obs();
    return {cpu_clk_en_o, flash_clk_en_o, io_clk_en_o, adc_clk_en_o, osc_run_o};
  endfunction

  // {cpu, flash, io, adc, osc} expected while asleep
  function automatic logic [4:0] exp_en(input logic [1:0] m);
    case (m)
      2'b00:   return 5'b00111;
      2'b01:   return 5'b00011;
      2'b11:   return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic bit allowed(input logic [1:0] m, input int b, input logic lvl);
    logic [3:0] mk;
    if (m == 2'b00) return 1'b1;
    mk = (m == 2'b01) ? ADC_M : DEEP_M;
    if (b == 0) return mk[0] && lvl;
    return mk[b];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // wait for the strobe, n counts sampled cycles from the request
  task automatic wake_and_time(input logic [1:0] m);
    int n = 0;
    int s = (m == 2'b10) ? SU : 0;
    bit seen = 0;
    for (int k = 0; k < 100 && !seen; k++) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (n == 1 && s > 0)
        chk(obs() == 5'b00001 && cpu_stall_o, "R11 startup", obs(), 5'b00001);
      if (n == s + 2)
        chk(obs() == 5'b11111 && cpu_stall_o, "R11 halt", {cpu_stall_o, obs()}, 6'b111111);
      if (n < s + 5 && wake_done_o) chk(0, "R8 early strobe", n, s + 5);
      if (wake_done_o) seen = 1;
    end
    chk(n == s + 5, "R8 latency", n, s + 5);
    chk(obs() == 5'b11111 && !cpu_stall_o, "R9 clocks at strobe", {cpu_stall_o, obs()}, 6'b011111);
    irq_req_i = '0;
    @(posedge clk); @(negedge clk);
    chk(!wake_done_o, "R9 single pulse", wake_done_o, 0);
  endtask

  task automatic enter_sleep(input logic [1:0] m);
    mode_i = m; slp_en_i = 1'b1; slp_pulse_i = 1'b1;
    @(posedge clk); @(negedge clk);
    slp_pulse_i = 1'b0;
    chk(obs() == exp_en(m) && cpu_stall_o, "R2 R3 R4 R5 mode enables", obs(), exp_en(m));
    // R12 stray pulse with another mode while asleep
    mode_i = ~m; slp_pulse_i = 1'b1;
    @(posedge clk); @(negedge clk);
    slp_pulse_i = 1'b0;
    chk(obs() == exp_en(m) && cpu_stall_o, "R12 stray pulse", obs(), exp_en(m));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(obs() == 5'b11111 && !cpu_stall_o && !wake_done_o, "R10 reset state", obs(), 5'b11111);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: pulse without enable in each mode
    for (int m = 0; m < 4; m++) begin
      mode_i = 2'(m); slp_en_i = 1'b0; slp_pulse_i = 1'b1;
      @(posedge clk); @(negedge clk);
      slp_pulse_i = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(obs() == 5'b11111 && !cpu_stall_o, "R1 enable low", obs(), 5'b11111);
    end

    // R6 R7 sweep
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < NIRQ; b++) begin
        for (int lv = 0; lv < 2; lv++) begin
          enter_sleep(2'(m));
          int0_level_i = 1'(lv);
          irq_req_i = '0;
          irq_req_i[b] = 1'b1;
          if (allowed(2'(m), b, 1'(lv))) begin
            wake_and_time(2'(m));
          end else begin
            repeat (8) @(negedge clk);
            chk(cpu_stall_o && obs() == exp_en(2'(m)) && !wake_done_o,
                "R6 R7 filtered request", obs(), exp_en(2'(m)));
            irq_req_i = 4'b0010;
            wake_and_time(2'(m));
          end
          @(negedge clk);
        end
      end
    end

    // R10 reset in Power-down
    enter_sleep(2'b10);
    rst_n = 1'b0;
    #1;
    chk(obs() == 5'b11111 && !cpu_stall_o, "R10 reset in sleep", obs(), 5'b11111);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (wake_done_o) chk(0, "R10 false strobe", 1, 0);
    end
    chk(!cpu_stall_o && obs() == 5'b11111, "R10 after release", obs(), 5'b11111);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

endmodule